// File: doc/BRIEF.md
# Keyboard Controller Host Register Interface

This block is the processor-facing side of a PC-style keyboard controller. A host reaches it through a one-byte read/write bus with two addresses: a data port and a combined command (write) / status (read) port. Codes from the keyboard side enter a byte queue through a push strobe. The host drains them through the data port. A keyboard interrupt tells the host that codes are waiting.

Commands written to the command port are often two-phase. Some set up a state in which the next data-port read returns the controller's command byte or output-port byte instead of queue data. Others make the next data-port write store into one of those bytes. A few commands act at once: they set or clear disable bits in the command byte, or queue a self-test reply. A data-port write outside the load states goes out on a one-cycle strobe to a keyboard-command responder. That responder answers through the same push input that carries keyboard codes.

Top module: `kbc_host_if`

## Requirements
- R1: After reset the status byte reads 0x10, the output-port byte reads 0x02, the command byte reads 0x00, and `kbd_irq`, `ovf_flag` and `kcmd_valid` are low. Receive interrupts are enabled.
- R2: In the idle state, a data-port read returns the oldest queued byte and removes it. Bytes leave in the order they were pushed.
- R3: A data-port read in the idle state with an empty queue returns the last byte returned by such a read, and then sets bit 7 of that remembered byte. The queue is left unchanged.
- R4: Command 0x20 makes the next data-port read return the command byte and go back to idle. While the read is pending, status bits 0 and 3 are set.
- R5: Command 0x60 makes the next data-port write store the command byte and go back to idle. That write also sets receive-interrupt-enable to (bit 0 OR bit 1) of the stored byte.
- R6: Command 0xD0 makes the next data-port read return the output-port byte, with status bit 0 set and bit 3 clear while it is pending. Command 0xD1 makes the next data-port write store the output-port byte.
- R7: Commands 0xAD and 0xAE set and clear command-byte bit 4 (keyboard disable). Commands 0xA7 and 0xA8 set and clear bit 5 (mouse disable). None of these four changes the pending state.
- R8: Command 0xAA pushes 0x55 into the queue. If an external push arrives in the same cycle, the external byte is dropped and `ovf_flag` is set.
- R9: Any command value other than 0x20, 0x60, 0xD0, 0xD1, 0xA7, 0xA8, 0xAA, 0xAD or 0xAE returns the state to idle.
- R10: `kbd_irq` is high exactly when the queue is non-empty, receive interrupts are enabled and command-byte bit 4 is clear.
- R11: A data-port write outside the two load states raises `kcmd_valid` for the single cycle after the write, with `kcmd_byte` equal to the written byte. A write in a load state is not forwarded.
- R12: A push into a full queue of DEPTH bytes is dropped and sets `ovf_flag`. The flag stays set until reset. The bytes already queued are kept intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Host access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 1 | 0 = data port, 1 = command/status port |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle of a read access |
| kbd_push | input | 1 | Push strobe for a byte from the keyboard side |
| kbd_code | input | 8 | Byte to push |
| kcmd_valid | output | 1 | One-cycle strobe of a forwarded data-port write |
| kcmd_byte | output | 8 | Forwarded byte |
| kbd_irq | output | 1 | Keyboard receive interrupt |
| ovf_flag | output | 1 | Sticky queue overrun flag |

## Verification
A wrong pending state shows at the very next status read as bit 3 or bit 0 out of place. It also shows at the next data-port read as a command or output byte where a queue byte was due, or the other way round. A bad queue pointer or count shows as codes returned out of order, as a missing bit-7 marking on an empty read, or as `kbd_irq` disagreeing with queue occupancy right after the push or pop edge. Command-byte corruption appears the first time 0x20 is issued, and also through `kbd_irq` as soon as a code is queued.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LD_CB  = 3'd1,
        ST_RD_CB  = 3'd2,
        ST_LD_OUT = 3'd3,
        ST_RD_OUT = 3'd4
    } kbc_state_e;

    // command-port opcodes
    localparam logic [BYTE_W-1:0] OP_RD_CB     = 8'h20;
    localparam logic [BYTE_W-1:0] OP_LD_CB     = 8'h60;
    localparam logic [BYTE_W-1:0] OP_RD_OUT    = 8'hD0;
    localparam logic [BYTE_W-1:0] OP_LD_OUT    = 8'hD1;
    localparam logic [BYTE_W-1:0] OP_AUX_OFF   = 8'hA7;
    localparam logic [BYTE_W-1:0] OP_AUX_ON    = 8'hA8;
    localparam logic [BYTE_W-1:0] OP_SELFTEST  = 8'hAA;
    localparam logic [BYTE_W-1:0] OP_KEY_OFF   = 8'hAD;
    localparam logic [BYTE_W-1:0] OP_KEY_ON    = 8'hAE;

    localparam logic [BYTE_W-1:0] SELFTEST_OK  = 8'h55;
    localparam logic [BYTE_W-1:0] STALE_MARK   = 8'h80;

    // command byte bit positions
    localparam int CB_KEY_IE  = 0;
    localparam int CB_AUX_IE  = 1;
    localparam int CB_KEY_DIS = 4;
    localparam int CB_AUX_DIS = 5;

    // status byte bit positions
    localparam int SB_FULL    = 0;
    localparam int SB_CB_PEND = 3;
    localparam int SB_UNLOCK  = 4;

endpackage

// File: rtl/kbc_byte_queue.sv
module kbc_byte_queue #(
    parameter int DEPTH = 256,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    input  logic         force_ovf,
    output logic [W-1:0] head_data,
    output logic         empty,
    output logic         overrun
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          ovf;
    } queue_regs_t;

    queue_regs_t q_q, q_d;
    logic [W-1:0] mem_q [DEPTH];
    logic pop_ok, push_ok;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + AW'(1);
    endfunction

    assign pop_ok  = pop && (q_q.cnt != '0);
    assign push_ok = push && ((q_q.cnt != FULL_CNT) || pop_ok);

    always_comb begin
        q_d = q_q;
        if (push_ok) q_d.wr = step(q_q.wr);
        if (pop_ok)  q_d.rd = step(q_q.rd);
        case ({push_ok, pop_ok})
            2'b10:   q_d.cnt = q_q.cnt + CW'(1);
            2'b01:   q_d.cnt = q_q.cnt - CW'(1);
            default: q_d.cnt = q_q.cnt;
        endcase
        if ((push && !push_ok) || force_ovf) q_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[q_q.wr] <= push_data;
    end

    assign head_data = mem_q[q_q.rd];
    assign empty     = (q_q.cnt == '0);
    assign overrun   = q_q.ovf;

endmodule

// File: rtl/kbc_ctrl.sv
module kbc_ctrl
    import kbc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] OUT_RST = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_sel,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              q_empty,
    input  logic [BYTE_W-1:0] q_head,
    output kbc_state_e        state,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic              rx_ie,
    output logic              q_pop,
    output logic              selftest_push,
    output logic              kcmd_valid,
    output logic [BYTE_W-1:0] kcmd_byte,
    output logic [BYTE_W-1:0] data_rd
);

    typedef struct packed {
        kbc_state_e        st;
        logic [BYTE_W-1:0] cb;
        logic [BYTE_W-1:0] outb;
        logic [BYTE_W-1:0] last;
        logic              ie;
        logic              fwd_v;
        logic [BYTE_W-1:0] fwd_b;
    } ctrl_regs_t;

    ctrl_regs_t r_q, r_d;
    logic pop_d, st_push_d;
    logic [BYTE_W-1:0] rd_val;

    always_comb begin
        r_d       = r_q;
        r_d.fwd_v = 1'b0;
        pop_d     = 1'b0;
        st_push_d = 1'b0;

        case (r_q.st)
            ST_RD_CB:  rd_val = r_q.cb;
            ST_RD_OUT: rd_val = r_q.outb;
            default:   rd_val = q_empty ? r_q.last : q_head;
        endcase

        if (bus_en && !bus_sel && !bus_we) begin
            // data-port read
            if (r_q.st == ST_RD_CB || r_q.st == ST_RD_OUT) begin
                r_d.st = ST_IDLE;
            end else if (!q_empty) begin
                pop_d     = 1'b1;
                r_d.last  = q_head;
            end else begin
                r_d.last  = r_q.last | STALE_MARK;
            end
        end else if (bus_en && !bus_sel && bus_we) begin
            // data-port write
            if (r_q.st == ST_LD_CB) begin
                r_d.cb = bus_wdata;
                r_d.ie = bus_wdata[CB_KEY_IE] | bus_wdata[CB_AUX_IE];
                r_d.st = ST_IDLE;
            end else if (r_q.st == ST_LD_OUT) begin
                r_d.outb = bus_wdata;
                r_d.st   = ST_IDLE;
            end else begin
                r_d.fwd_v = 1'b1;
                r_d.fwd_b = bus_wdata;
            end
        end else if (bus_en && bus_sel && bus_we) begin
            // command-port write
            case (bus_wdata)
                OP_RD_CB:    r_d.st = ST_RD_CB;
                OP_LD_CB:    r_d.st = ST_LD_CB;
                OP_RD_OUT:   r_d.st = ST_RD_OUT;
                OP_LD_OUT:   r_d.st = ST_LD_OUT;
                OP_AUX_OFF:  r_d.cb[CB_AUX_DIS] = 1'b1;
                OP_AUX_ON:   r_d.cb[CB_AUX_DIS] = 1'b0;
                OP_KEY_OFF:  r_d.cb[CB_KEY_DIS] = 1'b1;
                OP_KEY_ON:   r_d.cb[CB_KEY_DIS] = 1'b0;
                OP_SELFTEST: st_push_d = 1'b1;
                default:     r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.cb    <= '0;
            r_q.outb  <= OUT_RST;
            r_q.last  <= '0;
            r_q.ie    <= 1'b1;
            r_q.fwd_v <= 1'b0;
            r_q.fwd_b <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state         = r_q.st;
    assign cmd_byte      = r_q.cb;
    assign rx_ie         = r_q.ie;
    assign q_pop         = pop_d;
    assign selftest_push = st_push_d;
    assign kcmd_valid    = r_q.fwd_v;
    assign kcmd_byte     = r_q.fwd_b;
    assign data_rd       = rd_val;

endmodule

// File: rtl/kbc_status.sv
module kbc_status
    import kbc_pkg::*;
(
    input  kbc_state_e        state,
    input  logic              q_empty,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              rx_ie,
    output logic [BYTE_W-1:0] stat_byte,
    output logic              irq
);

    logic rd_pending;

    always_comb begin
        rd_pending = (state == ST_RD_CB) || (state == ST_RD_OUT);
        stat_byte             = '0;
        stat_byte[SB_FULL]    = !q_empty || rd_pending;
        stat_byte[SB_CB_PEND] = (state == ST_RD_CB);
        stat_byte[SB_UNLOCK]  = 1'b1;
        irq = !q_empty && rx_ie && !cmd_byte[CB_KEY_DIS];
    end

endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
    import kbc_pkg::*;
#(
    parameter int                DEPTH   = 256,
    parameter logic [BYTE_W-1:0] OUT_RST = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_sel,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              kbd_push,
    input  logic [BYTE_W-1:0] kbd_code,
    output logic              kcmd_valid,
    output logic [BYTE_W-1:0] kcmd_byte,
    output logic              kbd_irq,
    output logic              ovf_flag
);

    kbc_state_e        st_q;
    logic [BYTE_W-1:0] cb_q;
    logic              rx_ie_q;
    logic              q_pop, q_empty, st_push;
    logic [BYTE_W-1:0] q_head, data_rd, stat_byte;
    logic              q_push, q_clash;
    logic [BYTE_W-1:0] q_wdata;

    // self-test reply owns the single write slot of a cycle
    assign q_push  = st_push | kbd_push;
    assign q_wdata = st_push ? SELFTEST_OK : kbd_code;
    assign q_clash = st_push & kbd_push;

    kbc_byte_queue #(.DEPTH(DEPTH), .W(BYTE_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (q_wdata),
        .pop       (q_pop),
        .force_ovf (q_clash),
        .head_data (q_head),
        .empty     (q_empty),
        .overrun   (ovf_flag)
    );

    kbc_ctrl #(.OUT_RST(OUT_RST)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_en        (bus_en),
        .bus_we        (bus_we),
        .bus_sel       (bus_sel),
        .bus_wdata     (bus_wdata),
        .q_empty       (q_empty),
        .q_head        (q_head),
        .state         (st_q),
        .cmd_byte      (cb_q),
        .rx_ie         (rx_ie_q),
        .q_pop         (q_pop),
        .selftest_push (st_push),
        .kcmd_valid    (kcmd_valid),
        .kcmd_byte     (kcmd_byte),
        .data_rd       (data_rd)
    );

    kbc_status u_status (
        .state     (st_q),
        .q_empty   (q_empty),
        .cmd_byte  (cb_q),
        .rx_ie     (rx_ie_q),
        .stat_byte (stat_byte),
        .irq       (kbd_irq)
    );

    always_comb begin
        if (bus_en && !bus_we) bus_rdata = bus_sel ? stat_byte : data_rd;
        else                   bus_rdata = '0;
    end

endmodule

// File: rtl/kbc_host_if_chk.sv
module kbc_host_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_en,
    input logic       bus_we,
    input logic       bus_sel,
    input logic       kbd_push,
    input logic       kbd_irq,
    input logic       ovf_flag,
    input logic       kcmd_valid,
    input logic       q_empty,
    input logic [7:0] stat_byte
);

    // R10: the interrupt never fires without queued data
    a_r10_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_irq |-> !q_empty);

    // R12: overrun is sticky
    a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R12 / R8: overrun only appears after a push attempt
    a_r12_ovf_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(kbd_push));

    // R11: forwarding strobe only follows a data-port write
    a_r11_fwd_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        kcmd_valid |-> $past(bus_en && bus_we && !bus_sel));

    // R4: command-byte pending implies data-in-buffer
    a_r4_pend_implies_full: assert property (@(posedge clk) disable iff (!rst_n)
        stat_byte[3] |-> stat_byte[0]);

    // R4: a data-port read consumes the pending command byte
    a_r4_read_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && !bus_sel && stat_byte[3]) |=> !stat_byte[3]);

endmodule

bind kbc_host_if kbc_host_if_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_sel    (bus_sel),
    .kbd_push   (kbd_push),
    .kbd_irq    (kbd_irq),
    .ovf_flag   (ovf_flag),
    .kcmd_valid (kcmd_valid),
    .q_empty    (q_empty),
    .stat_byte  (stat_byte)
);

// File: tb/kbc_host_if_tb.sv
`timescale 1ns/1ps
module kbc_host_if_tb_top;

    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0, bus_we = 1'b0, bus_sel = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       kbd_push = 1'b0;
    logic [7:0] kbd_code = '0;
    logic       kcmd_valid;
    logic [7:0] kcmd_byte;
    logic       kbd_irq, ovf_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    kbc_host_if #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kbd_push(kbd_push), .kbd_code(kbd_code), .kcmd_valid(kcmd_valid),
        .kcmd_byte(kcmd_byte), .kbd_irq(kbd_irq), .ovf_flag(ovf_flag)
    );

    // ops: 0 data write, 1 command write, 2 data read, 3 status read
    // entry = {requirement number, op, write byte, expected read byte}
    localparam int NV = 37;
    localparam logic [21:0] VEC [NV] = '{
        {4'd1, 2'd3, 8'h00, 8'h10},   // R1 idle status
        {4'd4, 2'd1, 8'h20, 8'h00},
        {4'd4, 2'd3, 8'h00, 8'h19},   // R4 pending status
        {4'd4, 2'd2, 8'h00, 8'h00},   // R4 reset command byte
        {4'd4, 2'd3, 8'h00, 8'h10},   // R4 back to idle
        {4'd5, 2'd1, 8'h60, 8'h00},
        {4'd5, 2'd0, 8'h13, 8'h00},
        {4'd5, 2'd1, 8'h20, 8'h00},
        {4'd5, 2'd2, 8'h00, 8'h13},   // R5 stored
        {4'd7, 2'd1, 8'hAE, 8'h00},
        {4'd7, 2'd1, 8'hA7, 8'h00},
        {4'd7, 2'd1, 8'h20, 8'h00},
        {4'd7, 2'd2, 8'h00, 8'h23},   // R7 bit4 clear, bit5 set
        {4'd6, 2'd1, 8'hD0, 8'h00},
        {4'd6, 2'd3, 8'h00, 8'h11},   // R6 status during output read
        {4'd6, 2'd2, 8'h00, 8'h02},   // R6/R1 reset output byte
        {4'd6, 2'd1, 8'hD1, 8'h00},
        {4'd6, 2'd0, 8'hC3, 8'h00},
        {4'd6, 2'd1, 8'hD0, 8'h00},
        {4'd6, 2'd2, 8'h00, 8'hC3},   // R6 stored output byte
        {4'd8, 2'd1, 8'hAA, 8'h00},
        {4'd8, 2'd3, 8'h00, 8'h11},   // R8 reply queued
        {4'd8, 2'd2, 8'h00, 8'h55},   // R8 reply value
        {4'd3, 2'd2, 8'h00, 8'h55},   // R3 empty read repeats
        {4'd3, 2'd2, 8'h00, 8'hD5},   // R3 marked
        {4'd3, 2'd2, 8'h00, 8'hD5},   // R3 stays marked
        {4'd9, 2'd1, 8'h20, 8'h00},
        {4'd9, 2'd1, 8'h99, 8'h00},
        {4'd9, 2'd3, 8'h00, 8'h10},   // R9 unknown -> idle
        {4'd9, 2'd2, 8'h00, 8'hD5},   // R9 no command byte read
        {4'd7, 2'd1, 8'hAD, 8'h00},
        {4'd7, 2'd1, 8'h20, 8'h00},
        {4'd7, 2'd2, 8'h00, 8'h33},   // R7 both disables
        {4'd7, 2'd1, 8'hA8, 8'h00},
        {4'd7, 2'd1, 8'hAE, 8'h00},
        {4'd7, 2'd1, 8'h20, 8'h00},
        {4'd7, 2'd2, 8'h00, 8'h03}    // R7 both cleared
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic sel, input logic we, input logic [7:0] wd,
                          output logic [7:0] rd);
        @(negedge clk);
        bus_en = 1'b1; bus_sel = sel; bus_we = we; bus_wdata = wd;
        #1;
        rd = bus_rdata;
        @(posedge clk);
        #1;
        bus_en = 1'b0; bus_we = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic push(input logic [7:0] c);
        @(negedge clk);
        kbd_push = 1'b1; kbd_code = c;
        @(posedge clk);
        #1;
        kbd_push = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        do_reset();

        // R1 reset outputs
        #1;
        check("R1 irq", {7'd0, kbd_irq}, 8'h00);
        check("R1 ovf", {7'd0, ovf_flag}, 8'h00);
        check("R1 kcmd_valid", {7'd0, kcmd_valid}, 8'h00);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            logic [3:0] rq;
            logic [1:0] op;
            logic [7:0] wd, ex;
            {rq, op, wd, ex} = VEC[i];
            access(op[0], !op[1], wd, rd);
            if (op[1]) check($sformatf("R%0d vector %0d", rq, i), rd, ex);
        end

        // R2 / R10: order and interrupt (command byte now 0x03)
        push(8'h1E); push(8'h9E); push(8'h30);
        check("R10 irq with data", {7'd0, kbd_irq}, 8'h01);
        access(1'b1, 1'b1, 8'hAD, rd);
        check("R10 irq masked by key disable", {7'd0, kbd_irq}, 8'h00);
        access(1'b1, 1'b1, 8'hAE, rd);
        check("R10 irq unmasked", {7'd0, kbd_irq}, 8'h01);
        access(1'b0, 1'b0, 8'h00, rd); check("R2 first", rd, 8'h1E);
        access(1'b0, 1'b0, 8'h00, rd); check("R2 second", rd, 8'h9E);
        access(1'b0, 1'b0, 8'h00, rd); check("R2 third", rd, 8'h30);
        check("R10 irq empty", {7'd0, kbd_irq}, 8'h00);

        // R5 interrupt enable from command byte bits 0/1
        access(1'b1, 1'b1, 8'h60, rd);
        access(1'b0, 1'b1, 8'h00, rd);
        push(8'h2C);
        check("R5 ie off", {7'd0, kbd_irq}, 8'h00);
        access(1'b1, 1'b1, 8'h60, rd);
        access(1'b0, 1'b1, 8'h02, rd);
        check("R5 aux bit enables", {7'd0, kbd_irq}, 8'h01);
        access(1'b0, 1'b0, 8'h00, rd); check("R2 after ie", rd, 8'h2C);

        // R11 forwarding
        access(1'b0, 1'b1, 8'hF4, rd);
        check("R11 strobe", {7'd0, kcmd_valid}, 8'h01);
        check("R11 byte", kcmd_byte, 8'hF4);
        @(posedge clk); #1;
        check("R11 single cycle", {7'd0, kcmd_valid}, 8'h00);
        access(1'b1, 1'b1, 8'h60, rd);
        access(1'b0, 1'b1, 8'h03, rd);
        check("R11 load not forwarded", {7'd0, kcmd_valid}, 8'h00);

        // R12 full queue
        for (int i = 0; i < DEPTH; i++) push(8'(i));
        check("R12 no ovf at full", {7'd0, ovf_flag}, 8'h00);
        push(8'hEE);
        check("R12 ovf set", {7'd0, ovf_flag}, 8'h01);
        begin
            int bad = 0;
            for (int i = 0; i < DEPTH; i++) begin
                access(1'b0, 1'b0, 8'h00, rd);
                if (rd !== 8'(i)) bad++;
            end
            check("R12 contents intact (mismatches)", 8'(bad), 8'h00);
        end
        access(1'b0, 1'b0, 8'h00, rd);
        check("R12 dropped byte absent", rd, 8'hFF);
        check("R12 ovf sticky", {7'd0, ovf_flag}, 8'h01);

        // R1 reset again, then R8 clash
        do_reset();
        #1;
        check("R1 ovf cleared", {7'd0, ovf_flag}, 8'h00);
        access(1'b1, 1'b1, 8'hD0, rd);
        access(1'b0, 1'b0, 8'h00, rd);
        check("R1 output byte", rd, 8'h02);
        @(negedge clk);
        bus_en = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_wdata = 8'hAA;
        kbd_push = 1'b1; kbd_code = 8'h77;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0; bus_sel = 1'b0; kbd_push = 1'b0;
        check("R8 clash sets ovf", {7'd0, ovf_flag}, 8'h01);
        access(1'b0, 1'b0, 8'h00, rd); check("R8 reply kept", rd, 8'h55);
        access(1'b1, 1'b0, 8'h00, rd); check("R8 external dropped", rd, 8'h10);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule